// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Unit

This block is a square grid of multiply-accumulate cells, N by N with N set by a parameter, that multiplies a stream of 8-bit activation vectors by a tile of 8-bit weights held inside the grid. A vector presented at the input is first staggered so that lane r reaches the grid r cycles after lane 0. Each activation then travels rightward one cell per clock, while each column carries a 32-bit running sum downward. Every cell adds its own product to the sum coming from above. At the bottom the column sums are re-aligned so that every output word describes the same input vector. One input vector is accepted every clock, and once the pipeline is full one result vector leaves every clock.

Weight tiles are written, a whole tile per write, into an internal queue that holds up to four tiles. The oldest queued tile moves on its own into a shadow copy held beside the working weights. A swap pulse then turns the shadow copy into the working weights in one cycle, so a new tile can be staged while the current one is in use. Each vector carries its own signed/unsigned flag, which travels through the grid beside the data.

Top module: `sa_matrix_unit`

## Requirements
- R1: After reset, `out_valid`, `wt_full` and `wt_shadow_ready` are low and the working weights are all zero, so a vector sent before any swap yields an all-zero result.
- R2: With `in_signed` low, output word c (bits c*32 +: 32) equals the sum over lanes r of act[r] times W[r][c], where act[r] is bits r*8 +: 8 of `in_act`, W[r][c] is bits (r*N+c)*8 +: 8 of the tile, and both operands are zero-extended. The sum wraps modulo 2^32.
- R3: With `in_signed` high, the same sum is formed with both 8-bit operands read as two's-complement values. The result is the 32-bit two's-complement sum.
- R4: A vector presented with `in_valid` high in cycle k appears on `out_psum`, with `out_valid` high, in cycle k+2N-1. Vectors on consecutive cycles come out on consecutive cycles, in order.
- R5: The signed/unsigned choice belongs to each vector. In a back-to-back stream with the flag changing from vector to vector, every result follows its own vector's flag.
- R6: The tile queue holds four tiles. `wt_full` is high while four tiles are queued. A write made while `wt_full` is high is dropped and never reaches the grid.
- R7: When the shadow copy is empty and the queue is not, the oldest tile moves into the shadow copy on the next clock, and `wt_shadow_ready` goes high. A `tile_swap` pulse while `wt_shadow_ready` is high raises `swap_ack` in that cycle. Vectors presented after that clock use the new tile, and the shadow copy is refilled from the queue.
- R8: A `tile_swap` pulse while `wt_shadow_ready` is low leaves `swap_ack` low and the working weights unchanged.
- R9: Cycles with `in_valid` low produce no `out_valid` and do not disturb the results of the valid vectors around them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_push | input | 1 | Write one tile into the queue |
| wt_tile | input | N*N*8 | Tile data, W[r][c] at bits (r*N+c)*8 |
| wt_full | output | 1 | Queue holds four tiles |
| tile_swap | input | 1 | Request to make the shadow tile the working tile |
| wt_shadow_ready | output | 1 | Shadow copy holds a tile |
| swap_ack | output | 1 | The swap request in this cycle is taken |
| in_valid | input | 1 | Activation vector present |
| in_signed | input | 1 | Operands of this vector are two's-complement |
| in_act | input | N*8 | Activation vector, lane r at bits r*8 |
| out_valid | output | 1 | Result vector present |
| out_psum | output | N*32 | Result vector, column c at bits c*32 |

## Verification
On every cycle the assertions check that the number of vectors in flight stays within the pipeline depth, and that no result appears without a vector still owed. They also check that the tile queue never exceeds its capacity, that the shadow copy is only filled from a non-empty queue, and that the working weights change only on a granted swap. The exact arithmetic under both operand modes, the fixed latency, the dropping of a write to a full queue, and the order in which staged tiles reach the grid can be shown only by the bench's scenarios. The bench compares every result word with sums it computes itself.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int ACT_W = 8;
  localparam int SUM_W = 32;

  typedef struct packed {
    logic             sgn;
    logic [ACT_W-1:0] val;
  } act_t;

  // One cell's contribution: 8x8 product, extended to the sum width.
  function automatic logic [SUM_W-1:0] mac_term(input logic [ACT_W-1:0] a,
                                                input logic [ACT_W-1:0] w,
                                                input logic             sgn);
    logic signed [ACT_W:0]     ax;
    logic signed [ACT_W:0]     wx;
    logic signed [2*ACT_W+1:0] p;
    ax = sgn ? $signed({a[ACT_W-1], a}) : $signed({1'b0, a});
    wx = sgn ? $signed({w[ACT_W-1], w}) : $signed({1'b0, w});
    p  = (2*ACT_W+2)'(ax) * (2*ACT_W+2)'(wx);
    return {{(SUM_W-2*ACT_W-2){p[2*ACT_W+1]}}, p};
  endfunction
endpackage

// File: rtl/sa_delay.sv
module sa_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (D == 0) begin : g_wire
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] stg [D];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 0; k < D; k++) stg[k] <= '0;
        end else begin
          stg[0] <= d;
          for (int k = 1; k < D; k++) stg[k] <= stg[k-1];
        end
      end
      assign q = stg[D-1];
    end
  endgenerate
endmodule

// File: rtl/sa_pe.sv
module sa_pe
  import sa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  act_t             act_in,
  input  logic [ACT_W-1:0] weight,
  input  logic [SUM_W-1:0] psum_in,
  output act_t             act_out,
  output logic [SUM_W-1:0] psum_out
);
  logic [SUM_W-1:0] term;
  assign term = mac_term(act_in.val, weight, act_in.sgn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_out  <= '0;
      psum_out <= '0;
    end else begin
      act_out  <= act_in;
      psum_out <= psum_in + term;
    end
  end
endmodule

// File: rtl/sa_wbuf.sv
module sa_wbuf #(
  parameter int N     = 4,
  parameter int TILES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [N*N*8-1:0]  tile_in,
  input  logic              swap_req,
  output logic              full,
  output logic              shadow_ready,
  output logic              swap_ack,
  output logic [N*N*8-1:0]  active
);
  localparam int TW = N * N * 8;
  localparam int PW = $clog2(TILES);
  localparam int CW = $clog2(TILES + 1);

  logic [TW-1:0] mem [TILES];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [TW-1:0] shadow;
  logic          shadow_vld;

  // Named internal events
  logic push_ok, pop_fire, swap_fire;
  assign push_ok   = push && (count != CW'(TILES));
  assign pop_fire  = !shadow_vld && (count != '0);
  assign swap_fire = swap_req && shadow_vld;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= tile_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      shadow     <= '0;
      shadow_vld <= 1'b0;
      active     <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PW'(TILES-1)) ? '0 : wr_ptr + 1'b1;
      if (pop_fire) rd_ptr <= (rd_ptr == PW'(TILES-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_fire);
      if (pop_fire) begin
        shadow     <= mem[rd_ptr];
        shadow_vld <= 1'b1;
      end else if (swap_fire) begin
        shadow_vld <= 1'b0;
      end
      if (swap_fire) active <= shadow;
    end
  end

  assign full         = (count == CW'(TILES));
  assign shadow_ready = shadow_vld;
  assign swap_ack     = swap_fire;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(TILES)); // R6
  AST_SHADOW_FROM_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shadow_vld) |-> $past(count) != '0); // R7
  AST_WEIGHTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_req |=> $stable(active)); // R8
endmodule

// File: rtl/sa_matrix_unit.sv
module sa_matrix_unit
  import sa_pkg::*;
#(
  parameter int N     = 4,
  parameter int TILES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wt_push,
  input  logic [N*N*ACT_W-1:0] wt_tile,
  output logic                 wt_full,
  input  logic                 tile_swap,
  output logic                 wt_shadow_ready,
  output logic                 swap_ack,
  input  logic                 in_valid,
  input  logic                 in_signed,
  input  logic [N*ACT_W-1:0]   in_act,
  output logic                 out_valid,
  output logic [N*SUM_W-1:0]   out_psum
);
  localparam int LAT  = 2 * N - 1;
  localparam int AW   = $bits(act_t);
  localparam int CNTW = $clog2(LAT + 1) + 1;

  logic [N*N*ACT_W-1:0] active_w;
  logic [SUM_W-1:0]     vbus [N+1][N];

  sa_wbuf #(.N(N), .TILES(TILES)) u_wbuf (
    .clk          (clk),
    .rst_n        (rst_n),
    .push         (wt_push),
    .tile_in      (wt_tile),
    .swap_req     (tile_swap),
    .full         (wt_full),
    .shadow_ready (wt_shadow_ready),
    .swap_ack     (swap_ack),
    .active       (active_w)
  );

  for (genvar c = 0; c < N; c++) begin : g_top
    assign vbus[0][c] = '0;
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    act_t lane;
    act_t hb [N];
    act_t unused_east;
    assign lane = in_valid ? act_t'{sgn: in_signed, val: in_act[r*ACT_W +: ACT_W]} : '0;

    // Row r enters the grid r cycles late
    sa_delay #(.W(AW), .D(r)) u_skew (
      .clk (clk), .rst_n (rst_n), .d (lane), .q (hb[0])
    );

    for (genvar c = 0; c < N; c++) begin : g_col
      act_t east;
      sa_pe u_pe (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_in   (hb[c]),
        .weight   (active_w[(r*N+c)*ACT_W +: ACT_W]),
        .psum_in  (vbus[r][c]),
        .act_out  (east),
        .psum_out (vbus[r+1][c])
      );
      if (c < N - 1) begin : g_pass
        assign hb[c+1] = east;
      end else begin : g_edge
        assign unused_east = east;
      end
    end
  end

  // Column c leaves the grid c cycles late; pad it back into line
  for (genvar c = 0; c < N; c++) begin : g_deskew
    sa_delay #(.W(SUM_W), .D(N-1-c)) u_dsk (
      .clk (clk), .rst_n (rst_n), .d (vbus[N][c]), .q (out_psum[c*SUM_W +: SUM_W])
    );
  end

  sa_delay #(.W(1), .D(LAT)) u_vld (
    .clk (clk), .rst_n (rst_n), .d (in_valid), .q (out_valid)
  );

  // Vectors accepted but not yet delivered
  logic [CNTW-1:0] inflight;
  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + CNTW'(in_valid) - CNTW'(out_valid);
  end

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CNTW'(LAT)); // R4
  AST_NO_ORPHAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != '0); // R9
endmodule

// File: tb/tb_sa_matrix_unit.sv
module tb_sa_matrix_unit;
  localparam int N  = 4;
  localparam int TW = N * N * 8;
  localparam int VW = N * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wt_push = 1'b0;
  logic [TW-1:0] wt_tile = '0;
  logic          wt_full;
  logic          tile_swap = 1'b0;
  logic          wt_shadow_ready;
  logic          swap_ack;
  logic          in_valid = 1'b0;
  logic          in_signed = 1'b0;
  logic [N*8-1:0] in_act = '0;
  logic          out_valid;
  logic [VW-1:0] out_psum;

  sa_matrix_unit #(.N(N), .TILES(4)) dut (
    .clk (clk), .rst_n (rst_n), .wt_push (wt_push), .wt_tile (wt_tile),
    .wt_full (wt_full), .tile_swap (tile_swap), .wt_shadow_ready (wt_shadow_ready),
    .swap_ack (swap_ack), .in_valid (in_valid), .in_signed (in_signed),
    .in_act (in_act), .out_valid (out_valid), .out_psum (out_psum)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [TW-1:0] model_tile = '0;
  logic [VW-1:0] exp_val [0:1023];
  int            exp_cyc [0:1023];
  string         exp_tag [0:1023];
  int            wr = 0;
  int            rd = 0;

  function automatic int opnd(input logic [7:0] b, input bit sgn);
    if (sgn) return int'($signed(b));
    return int'({24'd0, b});
  endfunction

  function automatic logic [VW-1:0] ref_mul(input logic [N*8-1:0] x,
                                            input logic [TW-1:0] t, input bit sgn);
    logic [VW-1:0] res;
    for (int c = 0; c < N; c++) begin
      int acc = 0;
      for (int r = 0; r < N; r++)
        acc += opnd(x[r*8 +: 8], sgn) * opnd(t[(r*N+c)*8 +: 8], sgn);
      res[c*32 +: 32] = acc;
    end
    return res;
  endfunction

  function automatic logic [TW-1:0] rand_tile();
    logic [TW-1:0] t;
    for (int i = 0; i < N*N; i++) t[i*8 +: 8] = 8'($urandom);
    return t;
  endfunction

  function automatic logic [N*8-1:0] rand_vec();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) v[i*8 +: 8] = 8'($urandom);
    return v;
  endfunction

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input logic [VW-1:0] act, input logic [VW-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Output monitor: each owed vector must appear in exactly its cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd != wr && exp_cyc[rd] == cyc) begin
        chk_bit(out_valid, 1'b1, {exp_tag[rd], " valid at 2N-1 (R4)"});
        chk_vec(out_psum, exp_val[rd], exp_tag[rd]);
        rd++;
      end else if (out_valid) begin
        chk_bit(out_valid, 1'b0, "R9 no output without a valid vector");
      end
    end
  end

  task automatic send(input bit v, input bit sgn, input logic [N*8-1:0] x, input string tag);
    @(posedge clk); #1;
    wt_push = 1'b0; tile_swap = 1'b0;
    in_valid = v; in_signed = sgn; in_act = x;
    if (v) begin
      exp_val[wr] = ref_mul(x, model_tile, sgn);
      exp_cyc[wr] = cyc + 2*N - 1;
      exp_tag[wr] = tag;
      wr++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 1'b0, rand_vec(), "");
  endtask

  task automatic push_tile(input logic [TW-1:0] t);
    @(posedge clk); #1;
    in_valid = 1'b0; tile_swap = 1'b0;
    wt_push = 1'b1; wt_tile = t;
  endtask

  task automatic swap(input bit expect_ack, input logic [TW-1:0] next_tile, input string tag);
    @(posedge clk); #1;
    in_valid = 1'b0; wt_push = 1'b0;
    tile_swap = 1'b1;
    @(negedge clk);
    chk_bit(swap_ack, expect_ack, tag);
    if (expect_ack) model_tile = next_tile;
  endtask

  logic [TW-1:0] tl [0:5];

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk_bit(out_valid, 1'b0, "R1 out_valid low after reset");
    chk_bit(wt_full, 1'b0, "R1 wt_full low after reset");
    chk_bit(wt_shadow_ready, 1'b0, "R1 shadow empty after reset");
    send(1'b1, 1'b0, 32'hFFFF_FFFF, "R1 zero weights give zero");
    send(1'b1, 1'b1, rand_vec(), "R1 zero weights give zero");
    idle(2*N + 2);

    // R8: swap with nothing staged
    swap(1'b0, '0, "R8 swap_ack low with empty shadow");
    send(1'b1, 1'b0, rand_vec(), "R8 weights unchanged after refused swap");
    idle(2*N + 2);

    // R7: stage tile A (all 0xFF) and swap it in
    push_tile({(N*N){8'hFF}});
    idle(2);
    chk_bit(wt_shadow_ready, 1'b1, "R7 shadow filled from queue");
    swap(1'b1, {(N*N){8'hFF}}, "R7 swap_ack with staged tile");
    idle(1);
    chk_bit(wt_shadow_ready, 1'b0, "R7 shadow empty after swap");
    send(1'b1, 1'b0, {N{8'hFF}}, "R2 unsigned 255*255 corner");
    send(1'b1, 1'b1, {N{8'hFF}}, "R3 signed -1*-1 corner");
    send(1'b1, 1'b1, {N{8'h80}}, "R3 signed -128*-1 corner");
    send(1'b1, 1'b0, {N{8'h80}}, "R2 unsigned 128*255 corner");
    idle(2*N + 2);

    // R6: fill the queue; the sixth write is dropped
    tl[0] = rand_tile(); tl[1] = rand_tile(); tl[2] = rand_tile();
    tl[3] = {(N*N){8'h80}}; tl[4] = rand_tile(); tl[5] = rand_tile();
    for (int i = 0; i < 6; i++) push_tile(tl[i]);
    idle(1);
    chk_bit(wt_full, 1'b1, "R6 wt_full with four tiles queued");
    chk_bit(wt_shadow_ready, 1'b1, "R7 shadow holds oldest tile");

    for (int k = 0; k < 5; k++) begin
      swap(1'b1, tl[k], "R7 staged tile swapped in order");
      idle(2);
      if (k == 0) begin
        chk_bit(wt_full, 1'b0, "R6 wt_full drops after refill");
        for (int i = 0; i < 20; i++) send(1'b1, 1'b0, rand_vec(), "R2 unsigned stream");
      end else if (k == 1) begin
        for (int i = 0; i < 20; i++) send(1'b1, 1'b1, rand_vec(), "R3 signed stream");
      end else if (k == 2) begin
        for (int i = 0; i < 30; i++)
          send(1'($urandom % 4 != 0), 1'($urandom % 2), rand_vec(), "R5 per-vector mode with gaps (R9)");
      end else if (k == 3) begin
        send(1'b1, 1'b1, {N{8'h80}}, "R3 signed -128*-128 corner");
        send(1'b1, 1'b1, {N{8'h7F}}, "R3 signed 127*-128 corner");
        send(1'b1, 1'b0, {N{8'h80}}, "R2 unsigned 128*128 corner");
      end else begin
        for (int i = 0; i < 30; i++)
          send(1'b1, 1'($urandom % 2), rand_vec(), "R5 back-to-back mixed modes");
      end
      idle(2*N + 2);
    end

    // R6/R8: the dropped tile never appears
    chk_bit(wt_shadow_ready, 1'b0, "R6 dropped write left nothing staged");
    swap(1'b0, '0, "R8 swap refused after queue drained");
    idle(1);
    for (int i = 0; i < 5; i++) send(1'b1, 1'($urandom % 2), rand_vec(), "R8 previous tile kept");
    idle(2*N + 2);
    chk_bit(rd == wr, 1'b1, "R4 every vector delivered");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R4 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule